// File: doc/BRIEF.md
# Per-Character Flash Attribute Controller

This block keeps one blink attribute bit for each of eight character positions on a dot-matrix display, and gives the scan logic one visibility gate per position. A host writes and reads the attribute bits over the display's shared strobe bus (chip enable, write and read strobes, five address lines, eight data lines). The attribute store answers only while the active-low flash-select line is low. Address lines 2..0 pick the position. Code 0 is the leftmost character and code 7 the rightmost.

A free-running divider splits the display clock into a square blink phase. One full blink cycle lasts 28,672 clocks, which is about 2 Hz with the usual display clock. A position is blanked only when three things hold together: its attribute bit is set, the global flash enable (bit 3 of the control word, held outside this block) is high, and the phase is in its blank half. At all other times the position is visible.

Top module: `flash_attr_ctrl`

## Requirements
- R1: While the reset synchronizer holds the block in reset, and after it releases, all eight attribute bits read 0 and every `show` bit is 1. The divider count also starts from zero. The internal reset ends on the second rising clock edge after `rst_n` goes high.
- R2: A write takes place on a rising edge when `cs_n`, `fl_n` and `wr_n` are low and `rd_n` is high. It stores `wdata[0]` into the position `addr[2:0]`: 1 sets the attribute and 0 clears it.
- R3: A write ignores `addr[4:3]` and `wdata[7:1]`. A strobe with `fl_n` high or `cs_n` high leaves every attribute bit unchanged.
- R4: When `cs_n`, `fl_n` and `rd_n` are low and `wr_n` is high, `rdata` is the stored bit of position `addr[2:0]` on bit 0, with zeros on bits 7..1. At all other times `rdata` is zero.
- R5: Bit i of `show` belongs to position code i, so `show[0]` is the leftmost character and `show[7]` the rightmost.
- R6: Let n be the number of clocks since the internal reset released. The blink phase is in its blank half exactly when n mod 28,672 is 14,336 or more.
- R7: `show[i]` is 0 exactly when attribute i is 1, `flash_en` is 1 and the phase is in its blank half.
- R8: While `flash_en` is 0, every `show` bit is 1.
- R9: A position whose attribute bit is 0 is always shown, whatever the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| fl_n | input | 1 | Flash-store select, active low |
| addr | input | 5 | Bus address; bits 2..0 pick the position |
| wdata | input | 8 | Write data; bit 0 is the attribute value |
| rdata | output | 8 | Read data; stored bit on bit 0 |
| flash_en | input | 1 | Global flash enable from the control word |
| show | output | 8 | Per-position visible gate, 1 = lit |

## Verification
The assertions check the following on every clock:
- the divider count stays within its period, and the phase turns to blank only at the half-period count;
- a qualified write lands in the addressed position, and every other cycle leaves the store untouched;
- no cleared position and no disabled display is ever blanked;
- the upper read bits stay zero.

Some behaviour only the bench's scenarios can show: the exact blink timing measured from reset release across two full periods, the way attribute patterns combine with the enable toggling in mid-phase, and the fact that the ignored address and data bits and the unselected strobes have no effect once the bits are read back.

// File: rtl/flash_attr_pkg.sv
package flash_attr_pkg;

  typedef enum logic {
    PH_SHOW  = 1'b0,
    PH_BLANK = 1'b1
  } blink_phase_e;

  // Count at which the blank half of a blink cycle starts.
  function automatic int unsigned half_point(input int unsigned period);
    return period / 2;
  endfunction

endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/flash_attr_store.sv
module flash_attr_store #(
  parameter int unsigned NPOS = 8,
  localparam int unsigned PW  = $clog2(NPOS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [PW-1:0]   waddr,
  input  logic            wbit,
  input  logic [PW-1:0]   raddr,
  output logic            rbit,
  output logic [NPOS-1:0] attr
);

  logic [NPOS-1:0] attr_q;
  logic [NPOS-1:0] attr_d;
  logic [NPOS-1:0] slot_en;

  for (genvar g = 0; g < NPOS; g++) begin : g_slot
    assign slot_en[g] = we && (waddr == PW'(g));

    always_comb begin
      attr_d[g] = attr_q[g];
      if (slot_en[g]) attr_d[g] = wbit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          attr_q[g] <= 1'b0;
      else if (slot_en[g]) attr_q[g] <= attr_d[g];
    end
  end

  assign attr = attr_q;
  assign rbit = attr_q[raddr];

  // R2: a qualified write lands in the addressed slot
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (attr_q[$past(waddr)] == $past(wbit)));

  // R3: the store keeps its value on cycles without a write
  assert_hold_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(attr_q));

endmodule

// File: rtl/flash_blink_div.sv
module flash_blink_div
  import flash_attr_pkg::*;
#(
  parameter int unsigned PERIOD = 28672,
  localparam int unsigned CW    = $clog2(PERIOD),
  localparam int unsigned HALF  = half_point(PERIOD)
) (
  input  logic         clk,
  input  logic         rst_n,
  output blink_phase_e phase
);

  localparam logic [CW-1:0] LAST_CNT = CW'(PERIOD - 1);
  localparam logic [CW-1:0] PRE_HALF = CW'(HALF - 1);
  localparam logic [CW-1:0] HALF_CNT = CW'(HALF);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  blink_phase_e  ph_q;
  blink_phase_e  ph_d;
  logic          wrap;
  logic          mid;

  always_comb begin
    wrap  = (cnt_q == LAST_CNT);
    mid   = (cnt_q == PRE_HALF);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    ph_d  = ph_q;
    if (wrap)     ph_d = PH_SHOW;
    else if (mid) ph_d = PH_BLANK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_SHOW;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase = ph_q;

  // R6: the count never leaves its period
  assert_cnt_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_CNT);

  // R6: the blank half starts exactly at the half count
  assert_blank_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_BLANK) && ($past(ph_q) == PH_SHOW) |-> cnt_q == HALF_CNT);

  // R6: the blank half ends exactly at the wrap
  assert_blank_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SHOW) && ($past(ph_q) == PH_BLANK) |-> cnt_q == '0);

endmodule

// File: rtl/flash_gate.sv
module flash_gate
  import flash_attr_pkg::*;
#(
  parameter int unsigned NPOS = 8
) (
  input  logic [NPOS-1:0] attr,
  input  logic            enable,
  input  blink_phase_e    phase,
  output logic [NPOS-1:0] show
);

  logic blank_now;

  always_comb begin
    blank_now = enable && (phase == PH_BLANK);
  end

  for (genvar g = 0; g < NPOS; g++) begin : g_pos
    always_comb begin
      show[g] = !(attr[g] && blank_now);
    end
  end

endmodule

// File: rtl/flash_attr_ctrl.sv
module flash_attr_ctrl
  import flash_attr_pkg::*;
#(
  parameter int unsigned NPOS   = 8,
  parameter int unsigned AW     = 5,
  parameter int unsigned DW     = 8,
  parameter int unsigned PERIOD = 28672
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            wr_n,
  input  logic            rd_n,
  input  logic            fl_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic            flash_en,
  output logic [NPOS-1:0] show
);

  localparam int unsigned PW = $clog2(NPOS);

  logic            srst_n;
  logic            sel;
  logic            wr_go;
  logic            rd_go;
  logic            rd_bit;
  logic [NPOS-1:0] attr;
  blink_phase_e    phase;

  flash_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    sel   = !cs_n && !fl_n;
    wr_go = sel && !wr_n && rd_n;
    rd_go = sel && !rd_n && wr_n;
  end

  flash_attr_store #(.NPOS(NPOS)) u_store (
    .clk   (clk),
    .rst_n (srst_n),
    .we    (wr_go),
    .waddr (addr[PW-1:0]),
    .wbit  (wdata[0]),
    .raddr (addr[PW-1:0]),
    .rbit  (rd_bit),
    .attr  (attr)
  );

  flash_blink_div #(.PERIOD(PERIOD)) u_div (
    .clk   (clk),
    .rst_n (srst_n),
    .phase (phase)
  );

  flash_gate #(.NPOS(NPOS)) u_gate (
    .attr   (attr),
    .enable (flash_en),
    .phase  (phase),
    .show   (show)
  );

  always_comb begin
    rdata = '0;
    if (rd_go) rdata[0] = rd_bit;
  end

  // R8: a disabled display never blanks anything
  assert_disabled_all_lit_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !flash_en |-> (&show));

  // R9: a cleared attribute never blanks its position
  assert_clear_pos_lit_R9: assert property (@(posedge clk) disable iff (!srst_n)
    ((~attr) & (~show)) == '0);

  // R4: the upper read bits stay zero
  assert_read_upper_zero_R4: assert property (@(posedge clk) disable iff (!srst_n)
    rdata[DW-1:1] == '0);

  // R1: the store is empty right after the internal reset releases
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_n) |-> attr == '0);

endmodule

// File: tb/flash_attr_ctrl_test.sv
module flash_attr_ctrl_test;

  localparam int P    = 28672;
  localparam int HALF = P / 2;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, wr_n, rd_n, fl_n, flash_en;
  logic [4:0] addr;
  logic [7:0] wdata, rdata, show;

  int checks = 0;
  int errors = 0;
  int k = 0;
  logic [7:0] m_attr = 8'h00;
  logic m_en = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  flash_attr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .fl_n(fl_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .flash_en(flash_en), .show(show)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h (k=%0d)", tag, act, exp, k);
    end
  endtask

  task automatic idle_bus();
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; fl_n = 1'b1;
    addr = 5'd0; wdata = 8'd0;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d,
                           input logic fl, input logic cs);
    @(negedge clk);
    cs_n = cs; fl_n = fl; wr_n = 1'b0; rd_n = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    if (!cs && !fl) m_attr[a[2:0]] = d[0];
    idle_bus();
  endtask

  task automatic bus_read(input string tag, input logic [4:0] a, input logic fl,
                          input logic [7:0] exp);
    @(negedge clk);
    cs_n = 1'b0; fl_n = fl; rd_n = 1'b0; wr_n = 1'b1; addr = a;
    #1;
    check8(tag, rdata, exp);
    idle_bus();
  endtask

  function automatic logic [7:0] show_model();
    logic ph;
    logic [7:0] r;
    ph = (k >= 2) && (((k - 2) % P) >= HALF);
    for (int i = 0; i < 8; i++) r[i] = !(m_attr[i] && m_en && ph);
    return r;
  endfunction

  task automatic sweep_until(input string tag, input int kend);
    while (k < kend) begin
      @(negedge clk);
      check8(tag, show, show_model());
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_bus();
    flash_en = 1'b1;
    m_en = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check8("R1 show in reset", show, 8'hFF);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check8("R1 show after release", show, 8'hFF);
    for (int i = 0; i < 8; i++) bus_read("R1 cleared read", 5'(i), 1'b0, 8'h00);

    // R2/R3: write each position with noise on ignored bits, then read all back
    for (int i = 0; i < 8; i++)
      bus_write({2'(i + 1), 3'(i)}, {7'(7'h55 ^ 7'(i)), 1'(i % 2)}, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++)
      bus_read("R2 readback", 5'(i), 1'b0, {7'b0, m_attr[i]});
    for (int i = 0; i < 8; i++) bus_write(5'(i), 8'h01, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) bus_read("R2 set all", {2'b11, 3'(i)}, 1'b0, 8'h01);

    // R3: unselected strobes leave the store alone
    for (int i = 0; i < 8; i++) begin
      bus_write(5'(i), 8'h00, 1'b1, 1'b0);
      bus_write(5'(i), 8'h00, 1'b0, 1'b1);
    end
    for (int i = 0; i < 8; i++) bus_read("R3 unchanged", 5'(i), 1'b0, 8'h01);

    // R4: read with flash select high returns zero
    bus_read("R4 deselected read", 5'd3, 1'b1, 8'h00);

    // R5/R7: pattern 10100101 with enable on, across the first full period
    for (int i = 0; i < 8; i++) bus_write(5'(i), {7'h7F, 1'((8'hA5 >> i) & 1)}, 1'b0, 1'b0);
    bus_read("R5 leftmost", 5'd0, 1'b0, 8'h01);
    bus_read("R5 rightmost", 5'd7, 1'b0, 8'h01);
    bus_read("R5 pos1", 5'd1, 1'b0, 8'h00);
    sweep_until("R7 blink pattern A5", P + 200);

    // R8: enable off across a blank half
    @(negedge clk);
    flash_en = 1'b0; m_en = 1'b0;
    sweep_until("R8 enable off", P + HALF + 2000);

    // R9/R6: enable on mid-blank, new patterns into the second period
    @(negedge clk);
    flash_en = 1'b1; m_en = 1'b1;
    sweep_until("R6 blank resumes", P + HALF + 2100);
    for (int i = 0; i < 8; i++) bus_write(5'(i), {7'h00, 1'((8'h3C >> i) & 1)}, 1'b0, 1'b0);
    sweep_until("R9 pattern 3C", 2 * P + 300);
    for (int i = 0; i < 8; i++) bus_write(5'(i), 8'hFF, 1'b0, 1'b0);
    sweep_until("R6 all flagged", 2 * P + HALF + 300);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule